// File: doc/BRIEF.md
# Two-Stage PLL Control Registers with Lock-Wait Sequencer

This block is the firmware-facing control point for a two-stage clock synthesizer. It holds three 32-bit words behind a simple single-cycle register interface:
- a control word, which carries the power-down and bypass selects and shows the live lock status;
- a status word, which reports the lock-wait sequencer state;
- a divider word, which holds the two reference dividers, the two feedback multipliers and the output divider of the two stages.

The field values drive the analog PLL directly through dedicated output pins.

Each configuration change that needs the PLL to settle starts a bounded lock wait. Such changes are powering up, a bypass change while powered, or a divider change while powered. During the wait the sequencer polls the lock input once per cycle. The wait ends in one of two ways:
- **Done**: the lock input is seen high.
- **Timeout**: the lock does not appear within a fixed window of 70 microseconds, expressed in clock cycles by the parameters `CLK_MHZ` and `TIMEOUT_US`. The timeout flag is sticky until the next wait starts.

When the bypass of both stages is selected, no lock is needed, so a started wait completes at once.

Top module: `pll_ctl_regs`

## Requirements
- R1: After reset:
  - the control word (offset 0x0) reads 0x0000_0080 while the lock input is low;
  - the status word (offset 0x4) reads 0;
  - the divider word (offset 0x8) reads 0;
  - the `pll_pd` output is 1.
- R2: Control word layout:
  - bit 7 is power-down (1 = powered down);
  - bit 5 is stage-1 bypass;
  - bit 4 is full (stage-2) bypass;
  - bit 31 reads the live lock input, and writes to it are ignored;
  - all other bits read zero.
- R3: Divider word layout:
  - bits 27:25 hold the stage-1 reference divider;
  - bits 24:19 hold the stage-2 reference divider;
  - bits 18:13 hold the stage-1 multiplier;
  - bits 12:7 hold the stage-2 multiplier;
  - bits 6:1 hold the output divider;
  - bits 31:28 and bit 0 read zero;
  - each field drives its own output pin.
- R4: Status word layout:
  - bit 0 is busy;
  - bit 1 is done;
  - bit 2 is timeout;
  - bit 3 is prepared, the inverse of power-down;
  - it is read-only, and its other bits read zero.
- R5: A control-word write with bit 7 = 0 starts a wait. From the next cycle, busy is 1 and done and timeout are 0. A start during a wait restarts the timeout window.
- R6: A control-word write with bit 7 = 1 starts no wait. It cancels any wait in progress, so busy is 0 in the next cycle.
- R7: A divider-word write starts a wait only while powered up. While powered down it leaves busy at 0.
- R8: If a wait starts with the full-bypass bit set, then from the next cycle done is 1 and busy is 0, whatever the lock input.
- R9: A lock input sampled high while busy ends the wait: busy falls and done rises on the next cycle.
- R10: With no lock seen, busy stays high for exactly `CLK_MHZ*TIMEOUT_US` cycles (7000 by default). Busy then falls and timeout sets, and timeout stays set until the next wait starts.
- R11: Addresses other than 0x0, 0x4 and 0x8 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 4 | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| lock_in | input | 1 | Lock indication from the PLL, synchronous to clk |
| pll_pd | output | 1 | Power-down to the PLL |
| pll_byp1 | output | 1 | Stage-1 bypass select |
| pll_byp2 | output | 1 | Full bypass select |
| pll_divr1 | output | 3 | Stage-1 reference divider |
| pll_divr2 | output | 6 | Stage-2 reference divider |
| pll_divf1 | output | 6 | Stage-1 multiplier |
| pll_divf2 | output | 6 | Stage-2 multiplier |
| pll_divq | output | 6 | Output divider |
| wait_busy | output | 1 | Lock wait in progress |
| wait_done | output | 1 | Last wait ended with lock or with full bypass |
| wait_timeout | output | 1 | Last wait expired without lock (sticky) |

## Verification
The assertions assume the following about the inputs:
- `lock_in` is already synchronous to `clk`;
- `wr_en` and `addr` are stable for the whole cycle around the sampling edge.

The lock-ends-wait property also assumes that no new write arrives in the cycle the lock is seen. The bench drives every input on the falling edge and toggles `lock_in` only between writes. It issues each write as a single-cycle strobe, so these conditions always hold.

// File: rtl/pll_ctl_pkg.sv
// Package: shared address map, bit positions and divider type for the
// PLL control block. Assumes byte addressing with 32-bit words.
package pll_ctl_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_STAT = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_DIV  = 4'h8;

    // Control word bit positions
    localparam int B_LOCK = 31;
    localparam int B_PD   = 7;
    localparam int B_BYP1 = 5;
    localparam int B_BYP2 = 4;

    // Divider word field LSB positions
    localparam int L_DIVR1 = 25;
    localparam int L_DIVR2 = 19;
    localparam int L_DIVF1 = 13;
    localparam int L_DIVF2 = 7;
    localparam int L_DIVQ  = 1;

    localparam int W_DIVR1 = 3;
    localparam int W_DIV6  = 6;

    // Status word bit positions
    localparam int S_BUSY = 0;
    localparam int S_DONE = 1;
    localparam int S_TO   = 2;
    localparam int S_PREP = 3;

    typedef struct packed {
        logic [W_DIVR1-1:0] divr1;
        logic [W_DIV6-1:0]  divr2;
        logic [W_DIV6-1:0]  divf1;
        logic [W_DIV6-1:0]  divf2;
        logic [W_DIV6-1:0]  divq;
    } pll_div_t;

endpackage

// File: rtl/pll_cfg_regs.sv
// Module: holds the control and divider fields, decodes writes and raises
// the start / cancel requests for the lock-wait sequencer.
// Assumes single-cycle write strobes and a synchronous active-low reset.
module pll_cfg_regs
    import pll_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic              pd_q,
    output logic              byp1_q,
    output logic              byp2_q,
    output pll_div_t          div_q,
    output logic              start_wait,
    output logic              skip_wait,
    output logic              cancel_wait
);

    logic wr_ctrl;
    logic wr_div;
    pll_div_t div_new;

    // Write decode for the two writable words
    always_comb begin
        wr_ctrl = wr_en && (addr == OFF_CTRL);
        wr_div  = wr_en && (addr == OFF_DIV);
    end

    // Extract divider fields from the write data
    always_comb begin
        div_new.divr1 = wdata[L_DIVR1 +: W_DIVR1];
        div_new.divr2 = wdata[L_DIVR2 +: W_DIV6];
        div_new.divf1 = wdata[L_DIVF1 +: W_DIV6];
        div_new.divf2 = wdata[L_DIVF2 +: W_DIV6];
        div_new.divq  = wdata[L_DIVQ  +: W_DIV6];
    end

    // Wait requests: power-up or bypass write while powered, divider write while powered
    always_comb begin
        start_wait  = (wr_ctrl && !wdata[B_PD]) || (wr_div && !pd_q);
        skip_wait   = wr_ctrl ? wdata[B_BYP2] : byp2_q;
        cancel_wait = wr_ctrl && wdata[B_PD];
    end

    // Control field storage, power-down set at reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q   <= 1'b1;
            byp1_q <= 1'b0;
            byp2_q <= 1'b0;
        end else if (wr_ctrl) begin
            pd_q   <= wdata[B_PD];
            byp1_q <= wdata[B_BYP1];
            byp2_q <= wdata[B_BYP2];
        end
    end

    // Divider field storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (wr_div) begin
            div_q <= div_new;
        end
    end

    AST_START_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        start_wait |=> !pd_q); // R5

    AST_CANCEL_POWERS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_wait |=> pd_q); // R6

    AST_UNMAPPED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != OFF_CTRL && addr != OFF_DIV)
        |=> ($stable(pd_q) && $stable(byp1_q) && $stable(byp2_q) && $stable(div_q))); // R11

endmodule

// File: rtl/pll_lock_waiter.sv
// Module: bounded lock-poll sequencer. A start either completes at once
// (full bypass) or polls lock_in each cycle until lock or timeout.
// Assumes lock_in is synchronous to clk.
module pll_lock_waiter #(
    parameter int CLK_MHZ    = 100,
    parameter int TIMEOUT_US = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic skip,
    input  logic cancel,
    input  logic lock_in,
    output logic busy,
    output logic done,
    output logic timeout
);

    localparam int TIMEOUT_CYC = CLK_MHZ * TIMEOUT_US;
    localparam int CNT_W       = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Poll state machine with timeout counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            timeout <= 1'b0;
            cnt     <= '0;
        end else if (cancel) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy    <= !skip;
            done    <= skip;
            timeout <= 1'b0;
            cnt     <= '0;
        end else if (busy) begin
            if (lock_in) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else if (cnt == CNT_LAST) begin
                busy    <= 1'b0;
                timeout <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!done && !timeout)); // R5

    AST_DONE_TO_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout)); // R10

    AST_SKIP_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && skip && !cancel) |=> (done && !busy)); // R8

    AST_LOCK_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lock_in && !start && !cancel) |=> (done && !busy)); // R9

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_LAST); // R10

endmodule

// File: rtl/pll_rd_mux.sv
// Module: assembles the three readable words and selects one by address.
// Assumes unmapped addresses must read zero.
module pll_rd_mux
    import pll_ctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              lock_in,
    input  logic              pd_q,
    input  logic              byp1_q,
    input  logic              byp2_q,
    input  pll_div_t          div_q,
    input  logic              busy,
    input  logic              done,
    input  logic              timeout,
    output logic [31:0]       rdata
);

    logic [31:0] w_ctrl;
    logic [31:0] w_stat;
    logic [31:0] w_div;

    // Build each word from its fields, unused bits zero
    always_comb begin
        w_ctrl         = '0;
        w_ctrl[B_LOCK] = lock_in;
        w_ctrl[B_PD]   = pd_q;
        w_ctrl[B_BYP1] = byp1_q;
        w_ctrl[B_BYP2] = byp2_q;

        w_stat         = '0;
        w_stat[S_BUSY] = busy;
        w_stat[S_DONE] = done;
        w_stat[S_TO]   = timeout;
        w_stat[S_PREP] = !pd_q;

        w_div                         = '0;
        w_div[L_DIVR1 +: W_DIVR1]     = div_q.divr1;
        w_div[L_DIVR2 +: W_DIV6]      = div_q.divr2;
        w_div[L_DIVF1 +: W_DIV6]      = div_q.divf1;
        w_div[L_DIVF2 +: W_DIV6]      = div_q.divf2;
        w_div[L_DIVQ  +: W_DIV6]      = div_q.divq;
    end

    // Address select
    always_comb begin
        case (addr)
            OFF_CTRL: rdata = w_ctrl;
            OFF_STAT: rdata = w_stat;
            OFF_DIV:  rdata = w_div;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/pll_ctl_regs.sv
// Module: top of the PLL control block. Connects the field registers, the
// lock-wait sequencer and the read mux, and drives the PLL control pins.
// Assumes lock_in is synchronous to clk and writes are single-cycle strobes.
module pll_ctl_regs
    import pll_ctl_pkg::*;
#(
    parameter int CLK_MHZ    = 100,
    parameter int TIMEOUT_US = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              lock_in,
    output logic              pll_pd,
    output logic              pll_byp1,
    output logic              pll_byp2,
    output logic [2:0]        pll_divr1,
    output logic [5:0]        pll_divr2,
    output logic [5:0]        pll_divf1,
    output logic [5:0]        pll_divf2,
    output logic [5:0]        pll_divq,
    output logic              wait_busy,
    output logic              wait_done,
    output logic              wait_timeout
);

    pll_div_t div_q;
    logic     start_wait;
    logic     skip_wait;
    logic     cancel_wait;

    pll_cfg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .pd_q        (pll_pd),
        .byp1_q      (pll_byp1),
        .byp2_q      (pll_byp2),
        .div_q       (div_q),
        .start_wait  (start_wait),
        .skip_wait   (skip_wait),
        .cancel_wait (cancel_wait)
    );

    pll_lock_waiter #(
        .CLK_MHZ    (CLK_MHZ),
        .TIMEOUT_US (TIMEOUT_US)
    ) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_wait),
        .skip    (skip_wait),
        .cancel  (cancel_wait),
        .lock_in (lock_in),
        .busy    (wait_busy),
        .done    (wait_done),
        .timeout (wait_timeout)
    );

    pll_rd_mux u_rd (
        .addr    (addr),
        .lock_in (lock_in),
        .pd_q    (pll_pd),
        .byp1_q  (pll_byp1),
        .byp2_q  (pll_byp2),
        .div_q   (div_q),
        .busy    (wait_busy),
        .done    (wait_done),
        .timeout (wait_timeout),
        .rdata   (rdata)
    );

    // Divider fields out to the PLL
    always_comb begin
        pll_divr1 = div_q.divr1;
        pll_divr2 = div_q.divr2;
        pll_divf1 = div_q.divf1;
        pll_divf2 = div_q.divf2;
        pll_divq  = div_q.divq;
    end

    AST_PD_STOPS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        pll_pd |-> !wait_busy); // R6

    AST_DIV_WRITE_POWERED_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_DIV && pll_pd && !wait_busy) |=> !wait_busy); // R7

endmodule

// File: tb/sim_pll_ctl_regs.sv
module sim_pll_ctl_regs;

    localparam int TMO = 100 * 70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        lock_in = 1'b0;
    logic        pll_pd, pll_byp1, pll_byp2;
    logic [2:0]  pll_divr1;
    logic [5:0]  pll_divr2, pll_divf1, pll_divf2, pll_divq;
    logic        wait_busy, wait_done, wait_timeout;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    pll_ctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .lock_in(lock_in), .pll_pd(pll_pd), .pll_byp1(pll_byp1),
        .pll_byp2(pll_byp2), .pll_divr1(pll_divr1), .pll_divr2(pll_divr2),
        .pll_divf1(pll_divf1), .pll_divf2(pll_divf2), .pll_divq(pll_divq),
        .wait_busy(wait_busy), .wait_done(wait_done), .wait_timeout(wait_timeout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(4'h0, v); chk("R1 ctrl", v, 32'h0000_0080);
        rd(4'h4, v); chk("R1 stat", v, 32'h0);
        rd(4'h8, v); chk("R1 div", v, 32'h0);
        chk("R1 pd pin", {31'b0, pll_pd}, 32'h1);
    endtask

    task automatic t_ctrl_fields;
        logic [31:0] v;
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); chk("R2 ctrl mask", v, 32'h0000_00B0);
        chk("R2 pins", {29'b0, pll_pd, pll_byp1, pll_byp2}, 32'h7);
        lock_in = 1'b1;
        rd(4'h0, v); chk("R2 lock bit", v, 32'h8000_00B0);
        lock_in = 1'b0;
        wr(4'h0, 32'h0000_0080);
        rd(4'h0, v); chk("R2 cleared", v, 32'h0000_0080);
    endtask

    task automatic t_div_fields;
        logic [31:0] v, exp;
        exp = (32'd5 << 25) | (32'h2A << 19) | (32'h15 << 13) | (32'h33 << 7) | (32'h0C << 1);
        wr(4'h8, exp | 32'hF000_0001);
        rd(4'h8, v); chk("R3 div word", v, exp);
        chk("R3 pins", {5'b0, pll_divr1, pll_divr2, pll_divf1, pll_divf2, pll_divq},
            {5'b0, 3'd5, 6'h2A, 6'h15, 6'h33, 6'h0C});
        chk("R7 no wait while down", {31'b0, wait_busy}, 32'h0);
    endtask

    task automatic t_stat_ro;
        logic [31:0] v;
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, v); chk("R4 stat read-only", v, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, v); chk("R11 unmapped read", v, 32'h0);
        rd(4'h0, v); chk("R11 ctrl unchanged", v, 32'h0000_0080);
    endtask

    task automatic t_lock_ok;
        logic [31:0] v;
        lock_in = 1'b0;
        wr(4'h0, 32'h0);
        rd(4'h4, v); chk("R5 busy after power-up", v, 32'h9);
        cyc(20);
        chk("R5 still polling", {31'b0, wait_busy}, 32'h1);
        lock_in = 1'b1;
        @(negedge clk);
        rd(4'h4, v); chk("R9 lock ends wait", v, 32'hA);
        lock_in = 1'b0;
    endtask

    task automatic t_byp2;
        logic [31:0] v;
        lock_in = 1'b0;
        wr(4'h0, 32'h10);
        rd(4'h4, v); chk("R8 bypass skips wait", v, 32'hA);
        wr(4'h0, 32'h0);
        chk("R5 restart clears done", {30'b0, wait_busy, wait_done}, 32'h2);
    endtask

    task automatic t_cancel;
        logic [31:0] v;
        wr(4'h0, 32'h80);
        rd(4'h4, v); chk("R6 power-down cancels", v, 32'h0);
        chk("R6 pd pin", {31'b0, pll_pd}, 32'h1);
    endtask

    task automatic t_timeout;
        logic [31:0] v;
        lock_in = 1'b0;
        wr(4'h0, 32'h0);
        cyc(3000);
        wr(4'h8, 32'h0000_0002);
        chk("R7 div write restarts", {31'b0, wait_busy}, 32'h1);
        cyc(TMO - 5);
        chk("R10 busy inside window", {31'b0, wait_busy}, 32'h1);
        cyc(10);
        rd(4'h4, v); chk("R10 timeout sticky", v, 32'hC);
        cyc(50);
        chk("R10 timeout held", {31'b0, wait_timeout}, 32'h1);
        wr(4'h0, 32'h0);
        rd(4'h4, v); chk("R10 new wait clears timeout", v, 32'h9);
        lock_in = 1'b1;
        @(negedge clk);
        chk("R9 lock after restart", {29'b0, wait_timeout, wait_done, wait_busy}, 32'h2);
        lock_in = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_ctrl_fields;
        t_div_fields;
        t_stat_ro;
        t_unmapped;
        t_lock_ok;
        t_byp2;
        t_cancel;
        t_timeout;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule